// File: doc/BRIEF.md
# Power-up configuration memory loader

At power-up this block fills a bank of configuration registers from a small external parallel read-only memory. It runs when the three-bit mode strap holds the value 1. Each read drives a 5-bit address and an active-low combined chip-select/output-enable, then samples 8-bit data. Every read is stretched to cover a slow memory access time.

The first read is from address 0. It must return the signature 0xAA, which shows that a memory is fitted. If the signature is found, the loader reads addresses 0 to 31 in order. It writes each byte into the register entry with the same index, then raises a done flag. If the signature is missing, the loader stops at once and raises a fallback flag. That flag tells the surrounding logic to keep the bus interface in its disabled mode. Both flags stay set until reset.

The read strobe length comes from two parameters, the memory access time and the clock period. It is rounded up to whole cycles, and one more cycle is added.

Top module: `cfg_rom_loader`

## Requirements
- R1: While the strap `mode_strap` differs from 1, `rom_cs_n` stays high, both flags stay low and every register entry stays 0.
- R2: While `rst_n` is low (synchronous), `rom_cs_n` is 1, `rom_addr` is 0, both flags are 0 and `cfg_regs` is all zeros.
- R3: Reads go to addresses 0, 1, 2 … 31, one read for each address. Between two reads the address rises by exactly one.
- R4: `rom_cs_n` stays low for exactly WAIT_CYC = ceil(ACCESS_NS / CLK_PERIOD_NS) + 1 cycles for each read. This is 14 cycles at 250 ns and 20 ns. The data is sampled at the clock edge that ends the last low cycle.
- R5: Between two reads, `rom_cs_n` is high for exactly one cycle. `rom_addr` changes only on edges after which `rom_cs_n` is high.
- R6: The byte read from address a is written to bits 8a+7 down to 8a of `cfg_regs`, on the sampling edge. After a good load, entry 0 holds 0xAA.
- R7: On the edge that samples address 31, `load_done` rises. After that, `rom_cs_n` stays high, `rom_addr` stays at 31 and `load_done` stays high until reset.
- R8: If the byte at address 0 is not 0xAA, `load_fallback` rises on that sampling edge. Nothing is written to the register bank, no more reads take place, and the flag stays high until reset.
- R9: `load_done` and `load_fallback` are never high together.
- R10: The strap is looked at only when the loader leaves its idle state. A change of the strap after loading has begun has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 3 | Bus mode strap; value 1 starts the loader |
| rom_cs_n | output | 1 | Active-low chip select / output enable to the memory |
| rom_addr | output | 5 | Memory address |
| rom_data | input | 8 | Data from the memory |
| cfg_regs | output | 256 | Register bank, entry a at bits 8a+7:8a |
| load_done | output | 1 | Sticky: all 32 entries loaded |
| load_fallback | output | 1 | Sticky: signature missing, disabled bus mode applies |

## Verification
Two things fall on the same sampling edge of address 0: the signature decision and the write of register entry 0. A mismatch must raise `load_fallback` and leave entry 0 at zero. A match must store 0xAA and go on to address 1. The bench provokes this with near-miss signatures (0xAB, 0x2A) and with an absent memory that reads 0xFF. On the last read, the write of entry 31 and the rise of `load_done` also share one edge. The behavioural model predicts the whole bank and both flags, and it is compared with the design on every clock. The bench memory returns corrupt data until 13 cycles of strobe have passed, so a strobe that is too short shows up as wrong register contents.

// File: rtl/cfgld_pkg.sv
// Package for the configuration loader: the sequencer state type and a
// helper that turns an access time into a whole number of strobe cycles.
// Assumes the clock period and access time are given in nanoseconds.
package cfgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_READ,
        ST_DONE,
        ST_FALLBACK
    } ld_state_t;

    // Strobe length: access time rounded up to whole cycles, plus one margin cycle.
    function automatic int strobe_cycles(input int access_ns, input int period_ns);
        return (access_ns + period_ns - 1) / period_ns + 1;
    endfunction

endpackage

// File: rtl/cfgld_access_timer.sv
// Access timer: counts the cycles of one memory read strobe.
// Loaded by 'start' during the gap cycle before a read. While 'run' is high,
// it counts down to zero. 'expired' marks the last strobe cycle, which is
// the cycle at whose end the data is sampled.
// Assumes 'start' and 'run' are never high in the same cycle.
module cfgld_access_timer #(
    parameter int WAIT_CYC = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the strobe length on start, then count down while the strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(WAIT_CYC - 1);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The strobe ends when the count reaches zero while running.
    assign expired = run && (cnt_q == '0);

    // R4: the timer is never reloaded in the middle of a strobe.
    a_r4_start_outside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);

    // R4: once the count reaches zero during a strobe, the strobe must end.
    a_r4_expiry_ends_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !run);

endmodule

// File: rtl/cfgld_addr_seq.sv
// Address sequencer: holds the current memory address. It steps up by one
// on request and reports whether it points at the first or last entry.
// Assumes 'step' is never raised while the address is at its maximum.
module cfgld_addr_seq #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              is_first,
    output logic              is_last
);
    logic [ADDR_W-1:0] addr_q;

    // Hold the address, advancing by one on each step request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr     = addr_q;
    assign is_first = (addr_q == '0);
    assign is_last  = &addr_q;

    // R3: the address never wraps past the top of the map.
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        is_last |-> !step);

endmodule

// File: rtl/cfgld_reg_bank.sv
// Configuration register bank: 2**ADDR_W entries of DATA_W bits. It has a
// single write port, and all entries are visible at once on a flat output
// bus (entry i at bits i*DATA_W and up). Entries clear to zero on reset.
module cfgld_reg_bank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                waddr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [(DATA_W << ADDR_W)-1:0]    regs
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [DATA_W-1:0] val_q;

        // Capture write data when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (we && waddr == ADDR_W'(i)) begin
                val_q <= wdata;
            end
        end

        assign regs[i*DATA_W +: DATA_W] = val_q;
    end

endmodule

// File: rtl/cfg_rom_loader.sv
// Power-up configuration loader. When the strap selects memory-read mode,
// it reads a signature at address 0. If the signature matches, it copies
// the whole memory map into the register bank. If not, it flags a fallback
// to the disabled bus mode. Each read holds the chip select low long enough
// to cover ACCESS_NS at CLK_PERIOD_NS. Between reads the chip select is
// high for one cycle, and the address moves only then.
// Assumes the memory drives valid data before the strobe ends.
module cfg_rom_loader
    import cfgld_pkg::*;
#(
    parameter int          ADDR_W        = 5,
    parameter int          DATA_W        = 8,
    parameter int          CLK_PERIOD_NS = 20,
    parameter int          ACCESS_NS     = 250,
    parameter logic [2:0]  LOAD_MODE     = 3'd1,
    parameter logic [7:0]  SIGNATURE     = 8'hAA
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    mode_strap,
    output logic                          rom_cs_n,
    output logic [ADDR_W-1:0]             rom_addr,
    input  logic [DATA_W-1:0]             rom_data,
    output logic [(DATA_W << ADDR_W)-1:0] cfg_regs,
    output logic                          load_done,
    output logic                          load_fallback
);
    localparam int WAIT_CYC = strobe_cycles(ACCESS_NS, CLK_PERIOD_NS);

    ld_state_t state_q, state_d;
    logic      tmr_start, tmr_expired;
    logic      addr_step, addr_first, addr_last;
    logic      bank_we;
    logic      sig_ok;

    // Compare the sampled byte with the signature (only the low 8 bits carry it).
    assign sig_ok = (rom_data[7:0] == SIGNATURE);

    // Next-state and control decode of the read sequencer.
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        addr_step = 1'b0;
        bank_we   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (mode_strap == LOAD_MODE) state_d = ST_GAP;
            end
            ST_GAP: begin
                tmr_start = 1'b1;
                state_d   = ST_READ;
            end
            ST_READ: begin
                if (tmr_expired) begin
                    if (addr_first && !sig_ok) begin
                        state_d = ST_FALLBACK;
                    end else begin
                        bank_we = 1'b1;
                        if (addr_last) begin
                            state_d = ST_DONE;
                        end else begin
                            addr_step = 1'b1;
                            state_d   = ST_GAP;
                        end
                    end
                end
            end
            ST_DONE:     state_d = ST_DONE;
            ST_FALLBACK: state_d = ST_FALLBACK;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign rom_cs_n      = (state_q != ST_READ);
    assign load_done     = (state_q == ST_DONE);
    assign load_fallback = (state_q == ST_FALLBACK);

    cfgld_access_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (!rom_cs_n),
        .expired (tmr_expired)
    );

    cfgld_addr_seq #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (addr_step),
        .addr     (rom_addr),
        .is_first (addr_first),
        .is_last  (addr_last)
    );

    cfgld_reg_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .waddr (rom_addr),
        .wdata (rom_data),
        .regs  (cfg_regs)
    );

    // R9: the two outcomes exclude each other.
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && load_fallback));

    // R7: done is sticky and the memory stays released.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done && rom_cs_n);

    // R8: fallback is sticky and no further read starts.
    a_r8_fallback_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_fallback |=> load_fallback && rom_cs_n);

    // R5: the address moves only on an edge that leaves the chip select high.
    a_r5_addr_moves_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr != $past(rom_addr)) |-> rom_cs_n);

    // R3: each address change is a step of exactly one.
    a_r3_addr_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr != $past(rom_addr)) |-> (rom_addr == $past(rom_addr) + 1'b1));

    // R6: the bank is written only while a read strobe is active.
    a_r6_write_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> !rom_cs_n);

    // R1: no read starts unless the strap selected the loader when leaving idle.
    a_r1_start_needs_strap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE && state_q == ST_GAP) |-> ($past(mode_strap) == LOAD_MODE));

endmodule

// File: tb/cfg_rom_loader_bench.sv
// Bench for cfg_rom_loader: a behavioural memory and a cycle model of the
// expected outputs. The model is compared with the design at every falling edge.
module cfg_rom_loader_bench;

    localparam int ACC_CYC = 13;   // ceil(250 ns / 20 ns): memory data valid after this many strobe cycles
    localparam int WAIT_N  = 14;   // expected strobe length (R4)

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode_strap = 3'd0;
    logic         rom_cs_n;
    logic [4:0]   rom_addr;
    logic [7:0]   rom_data = 8'h00;
    logic [255:0] cfg_regs;
    logic         load_done, load_fallback;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    cfg_rom_loader u_cfg_rom_loader (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_strap    (mode_strap),
        .rom_cs_n      (rom_cs_n),
        .rom_addr      (rom_addr),
        .rom_data      (rom_data),
        .cfg_regs      (cfg_regs),
        .load_done     (load_done),
        .load_fallback (load_fallback)
    );

    // Memory image seen by the bench memory model.
    logic [7:0] img [32];

    // Reference model state.
    typedef enum int {M_IDLE, M_GAP, M_LOW, M_DONE, M_FAIL} mph_t;
    mph_t         m_ph = M_IDLE;
    int           m_cnt = 0;
    int           m_addr = 0;
    logic [255:0] m_regs = '0;
    int           low_cnt = 0;

    // Reference model: advances on the same edges as the design.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = M_IDLE; m_addr = 0; m_cnt = 0; m_regs = '0;
        end else begin
            case (m_ph)
                M_IDLE: if (mode_strap == 3'd1) m_ph = M_GAP;      // R1, R10
                M_GAP:  begin m_ph = M_LOW; m_cnt = WAIT_N - 1; end
                M_LOW: begin
                    if (m_cnt == 0) begin
                        if (m_addr == 0 && img[0] != 8'hAA) begin
                            m_ph = M_FAIL;                          // R8
                        end else begin
                            m_regs[m_addr*8 +: 8] = img[m_addr];    // R6
                            if (m_addr == 31) m_ph = M_DONE;        // R7
                            else begin m_addr++; m_ph = M_GAP; end  // R3, R5
                        end
                    end else m_cnt--;
                end
                default: ;
            endcase
        end
    end

    task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string req, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare at the falling edge, then drive the memory data for the next rising edge.
    always @(negedge clk) begin
        chk({255'd0, rom_cs_n}, {255'd0, m_ph != M_LOW}, rst_n ? "R4" : "R2", "rom_cs_n");
        chk({251'd0, rom_addr}, {251'd0, 5'(m_addr)}, rst_n ? "R3" : "R2", "rom_addr");
        chk(cfg_regs, m_regs, rst_n ? "R6" : "R2", "cfg_regs");
        chk({255'd0, load_done}, {255'd0, m_ph == M_DONE}, "R7", "load_done");
        chk({255'd0, load_fallback}, {255'd0, m_ph == M_FAIL}, "R8", "load_fallback");
        chk({255'd0, load_done & load_fallback}, 256'd0, "R9", "both flags");
        if (!rom_cs_n) low_cnt++;
        else low_cnt = 0;
        // R4: corrupt data until the access time has elapsed
        rom_data = (low_cnt >= ACC_CYC) ? img[rom_addr] : ~img[rom_addr];
    end

    task automatic fill(input int kind);
        for (int a = 0; a < 32; a++) begin
            case (kind)
                0: img[a] = 8'((a * 37 + 11) % 256);
                1: img[a] = 8'(~(a * 5));
                2: img[a] = (a % 2 == 0) ? 8'h00 : 8'hFF;
                default: img[a] = 8'hFF;   // no memory fitted
            endcase
        end
    endtask

    task automatic run(input logic [2:0] strap, input int kind, input logic [7:0] sig,
                       input int n, input int flip_at);
        fill(kind);
        img[0] = sig;
        @(negedge clk); rst_n = 1'b0; mode_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == flip_at) mode_strap = 3'd6;   // R10: change after start
        end
    endtask

    initial begin
        run(3'd0, 0, 8'hAA, 80, -1);     // R1, R2: strap 0
        run(3'd3, 0, 8'hAA, 80, -1);     // R1: strap 3
        run(3'd7, 0, 8'hAA, 80, -1);     // R1: strap 7
        run(3'd1, 0, 8'hAA, 560, -1);    // R3..R7: full load, then held
        run(3'd1, 1, 8'hAA, 520, 40);    // R10: strap changes mid-load
        run(3'd1, 2, 8'hAA, 520, -1);    // R6: alternating 00/FF data
        run(3'd1, 0, 8'hAB, 80, -1);     // R8: near-miss signature
        run(3'd1, 0, 8'h2A, 80, -1);     // R8: near-miss signature
        run(3'd1, 3, 8'hFF, 80, -1);     // R8: absent memory
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule